// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register core of a general-purpose I/O expander for a power-of-two number of pins, eight or more. The pins are split into banks of eight. A byte-wide register read/write port, of the kind that sits behind a serial-bus slave, reaches five register groups: direction, pin level, interrupt enable, interrupt status and one spare group. On the pin side, the block drives output values and output enables, and it takes raw input samples. These samples are synchronised before use. One registered interrupt line tells the host that an enabled pin event is pending.

The register address is the group index shifted left by S, plus the bank number. S is log2(pins) minus 3, so the stride between groups grows with the pin count. The host changes single pins by read-modify-write of a whole bank. It learns of input changes by reading the status registers, and each such read clears the bank it returns.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every direction, output, enable, spare and status bit is 0. `pin_oe`, `pin_out` and `irq` are 0, and every valid register reads 0x00.
- R2: A register sits at address (group << S) + bank, where S = log2(NUM_PINS) - 3. The groups are direction 0, level 1, enable 2, status 3 and spare 4. Bit i of bank b maps to pin 8*b + i.
- R3: Direction bit 1 makes the pin an output and bit 0 makes it an input. `pin_oe` equals the direction registers and changes only on a register write.
- R4: A write to a level register sets `pin_out` for that bank. A read of a level register returns `pin_in` after two synchroniser flops, not the written output values.
- R5: A status bit is set when its synchronised input changes in either direction. A read of its bank's status register returns the bits and then clears them. An event in the same cycle as the clearing read stays set.
- R6: `irq` is the OR over all pins of (status AND enable), registered by one cycle. It drops after the pending bits are cleared.
- R7: The enable registers read back what was written. A status bit whose enable is 0 still reads as set but does not raise `irq`.
- R8: The spare group is plain read/write storage of one byte per bank.
- R9: Addresses at or above 5 << S read 0x00. Writes to them change no register and no pin.
- R10: Writes to the status group are ignored.
- R11: Read data and `reg_rd_valid` appear in the cycle after `reg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | S+3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| reg_rd_valid | output | 1 | Read data valid, one cycle after the read strobe |
| pin_in | input | NUM_PINS | Raw pin input samples |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables (1 = drive) |
| irq | output | 1 | Registered interrupt to the host |

## Verification
The direction and level banks get different byte patterns (0xA5/0x3C and 0x0F/0xF0). A swapped bank, a wrong group stride or a level read that returns the output register then shows as a specific wrong byte. Input changes are driven as a rising and a falling edge, on pins in the two banks and in enabled and disabled banks. This separates edge detection from level sensing and shows whether the interrupt is gated by its enable. A pin change is also timed so that its event lands in the very cycle of a clearing status read, which shows whether the set takes priority over the clear. Writes to the status group and to every unused address are then followed by read-back of the valid registers and by checks on the pins. This proves that those writes changed nothing.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  localparam int BANK_BITS  = 8;
  localparam int NUM_GROUPS = 5;

  typedef enum logic [2:0] {
    GRP_DIR   = 3'd0,
    GRP_LVL   = 3'd1,
    GRP_IEN   = 3'd2,
    GRP_STAT  = 3'd3,
    GRP_SPARE = 3'd4
  } grp_e;

  // Shift between group base addresses: log2(pins) - 3
  function automatic int bank_shift(input int pins);
    return $clog2(pins) - 3;
  endfunction

  function automatic int group_of(input int addr, input int shift);
    return addr >> shift;
  endfunction

  function automatic int bank_of(input int addr, input int shift);
    return addr & ((1 << shift) - 1);
  endfunction

  // Status update: a fresh change wins over a clearing read
  function automatic logic [7:0] stat_next(input logic [7:0] cur,
                                           input logic [7:0] change,
                                           input logic       clear);
    return (clear ? 8'h00 : cur) | change;
  endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] change
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level  = sync_q;
  assign change = sync_q ^ prev_q;

endmodule

// File: rtl/gpx_addr_dec.sv
module gpx_addr_dec
  import gpx_pkg::*;
#(
  parameter int SHIFT  = 1,
  parameter int BANKS  = 2,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_GROUPS-1:0] grp_sel,
  output logic [BANKS-1:0]      bank_sel,
  output logic                  hit
);

  int grp_idx;
  int bank_idx;

  always_comb begin
    grp_idx  = group_of(int'(addr), SHIFT);
    bank_idx = bank_of(int'(addr), SHIFT);
    for (int g = 0; g < NUM_GROUPS; g++) grp_sel[g] = (grp_idx == g);
    for (int b = 0; b < BANKS; b++)      bank_sel[b] = (bank_idx == b);
    hit = (grp_idx < NUM_GROUPS);
  end

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_dir,
  input  logic       wr_lvl,
  input  logic       wr_ien,
  input  logic       wr_spare,
  input  logic       rd_stat,
  input  logic [7:0] wdata,
  input  logic [7:0] change,
  output logic [7:0] dir_q,
  output logic [7:0] out_q,
  output logic [7:0] ien_q,
  output logic [7:0] stat_q,
  output logic [7:0] spare_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
      spare_q <= '0;
    end else begin
      if (wr_dir)   dir_q   <= wdata;
      if (wr_lvl)   out_q   <= wdata;
      if (wr_ien)   ien_q   <= wdata;
      if (wr_spare) spare_q <= wdata;
      stat_q <= stat_next(stat_q, change, rd_stat);
    end
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpx_pkg::*;
#(
  parameter  int NUM_PINS = 16,
  localparam int SHIFT    = gpx_pkg::bank_shift(NUM_PINS),
  localparam int BANKS    = 1 << SHIFT,
  localparam int ADDR_W   = SHIFT + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic                reg_rd_valid,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  // Named internal events, brought out for the checker
  logic [NUM_PINS-1:0]   lvl_sync;
  logic [NUM_PINS-1:0]   evt_vec;
  logic [NUM_PINS-1:0]   stat_vec;
  logic [NUM_PINS-1:0]   ien_vec;
  logic [NUM_GROUPS-1:0] grp_sel;
  logic [BANKS-1:0]      bank_sel;
  logic                  addr_hit;
  logic [7:0]            rd_mux;

  logic [7:0] dir_b   [BANKS];
  logic [7:0] out_b   [BANKS];
  logic [7:0] ien_b   [BANKS];
  logic [7:0] stat_b  [BANKS];
  logic [7:0] spare_b [BANKS];

  gpx_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pin_in),
    .level  (lvl_sync),
    .change (evt_vec)
  );

  gpx_addr_dec #(.SHIFT(SHIFT), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr     (reg_addr),
    .grp_sel  (grp_sel),
    .bank_sel (bank_sel),
    .hit      (addr_hit)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic wr_any;
    logic rd_stat;
    assign wr_any  = reg_wr_en & addr_hit & bank_sel[b];
    assign rd_stat = reg_rd_en & addr_hit & bank_sel[b] & grp_sel[GRP_STAT];

    gpx_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_dir   (wr_any & grp_sel[GRP_DIR]),
      .wr_lvl   (wr_any & grp_sel[GRP_LVL]),
      .wr_ien   (wr_any & grp_sel[GRP_IEN]),
      .wr_spare (wr_any & grp_sel[GRP_SPARE]),
      .rd_stat  (rd_stat),
      .wdata    (reg_wdata),
      .change   (evt_vec[BANK_BITS*b +: BANK_BITS]),
      .dir_q    (dir_b[b]),
      .out_q    (out_b[b]),
      .ien_q    (ien_b[b]),
      .stat_q   (stat_b[b]),
      .spare_q  (spare_b[b])
    );

    assign pin_oe  [BANK_BITS*b +: BANK_BITS] = dir_b[b];
    assign pin_out [BANK_BITS*b +: BANK_BITS] = out_b[b];
    assign stat_vec[BANK_BITS*b +: BANK_BITS] = stat_b[b];
    assign ien_vec [BANK_BITS*b +: BANK_BITS] = ien_b[b];
  end

  // AND-OR read mux over the selected bank and group
  always_comb begin
    rd_mux = 8'h00;
    for (int b = 0; b < BANKS; b++) begin
      if (addr_hit && bank_sel[b]) begin
        rd_mux = rd_mux
               | ({8{grp_sel[GRP_DIR]}}   & dir_b[b])
               | ({8{grp_sel[GRP_LVL]}}   & lvl_sync[BANK_BITS*b +: BANK_BITS])
               | ({8{grp_sel[GRP_IEN]}}   & ien_b[b])
               | ({8{grp_sel[GRP_STAT]}}  & stat_b[b])
               | ({8{grp_sel[GRP_SPARE]}} & spare_b[b]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata    <= 8'h00;
      reg_rd_valid <= 1'b0;
      irq          <= 1'b0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      if (reg_rd_en) reg_rdata <= rd_mux;
      irq <= |(stat_vec & ien_vec);
    end
  end

endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
  parameter  int NUM_PINS = 16,
  localparam int ADDR_W   = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_en,
  input logic                reg_rd_en,
  input logic                addr_hit,
  input logic [7:0]          reg_rdata,
  input logic                reg_rd_valid,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] stat_vec,
  input logic [NUM_PINS-1:0] ien_vec,
  input logic [NUM_PINS-1:0] evt_vec,
  input logic                irq
);

  // R3: enables move only on a write
  p_oe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(pin_oe));

  // R4: output values move only on a write
  p_out_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(pin_out));

  // R5: a status bit never rises without a change event the cycle before
  p_stat_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_vec & ~$past(stat_vec)) & ~$past(evt_vec)) == '0);

  // R6: interrupt rises only from a pending status
  p_irq_needs_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|stat_vec));

  // R6: no status anywhere means the interrupt is low next cycle
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vec == '0) |=> !irq);

  // R7: with every enable off the interrupt stays low
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_vec == '0) |=> !irq);

  // R9: unused addresses read as zero
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !addr_hit) |=> (reg_rdata == 8'h00));

  // R11: valid follows the read strobe by one cycle
  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rd_valid);

  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rd_valid);

  initial begin
    p_width_r2: assert (ADDR_W >= 3);
  end

endmodule

bind gpio_bank_regs gpx_checker #(.NUM_PINS(NUM_PINS)) u_gpx_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_rd_en    (reg_rd_en),
  .addr_hit     (addr_hit),
  .reg_rdata    (reg_rdata),
  .reg_rd_valid (reg_rd_valid),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .stat_vec     (stat_vec),
  .ien_vec      (ien_vec),
  .evt_vec      (evt_vec),
  .irq          (irq)
);

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;

  localparam int NUM_PINS = 16;
  localparam int BANKS    = NUM_PINS / 8;
  localparam int ADDR_W   = $clog2(NUM_PINS);
  localparam int NADDR    = 1 << ADDR_W;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                reg_wr_en = 1'b0;
  logic                reg_rd_en = 1'b0;
  logic [ADDR_W-1:0]   reg_addr = '0;
  logic [7:0]          reg_wdata = '0;
  logic [7:0]          reg_rdata;
  logic                reg_rd_valid;
  logic [NUM_PINS-1:0] pin_in = '0;
  logic [NUM_PINS-1:0] pin_out;
  logic [NUM_PINS-1:0] pin_oe;
  logic                irq;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_gpio_bank_regs (
    .clk, .rst_n, .reg_wr_en, .reg_rd_en, .reg_addr, .reg_wdata,
    .reg_rdata, .reg_rd_valid, .pin_in, .pin_out, .pin_oe, .irq
  );

  // Address of group g, bank b: one stride of BANKS per group
  function automatic logic [ADDR_W-1:0] ra(input int g, input int b);
    return ADDR_W'(g * BANKS + b);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // Driver: pushes the expected byte, the monitor compares it
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    reg_rd_en = 1'b0;
    check("R11 valid", 32'(reg_rd_valid), 32'd1);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (reg_rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_fail++;
        $display("FAIL R11: actual unexpected read %h expected none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(reg_rdata), 32'(e));
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    check("R1 oe", 32'(pin_oe), 32'h0);
    check("R1 out", 32'(pin_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R11 idle", 32'(reg_rd_valid), 32'h0);
    for (int g = 0; g < 5; g++)
      for (int b = 0; b < BANKS; b++) rd(ra(g, b), 8'h00, "R1 reset read");

    // R2/R3 direction mapping
    wr(ra(0, 0), 8'hA5);
    wr(ra(0, 1), 8'h3C);
    check("R3 pin_oe", 32'(pin_oe), 32'h3CA5);
    rd(ra(0, 0), 8'hA5, "R2 dir bank0");
    rd(ra(0, 1), 8'h3C, "R2 dir bank1");

    // R4 output values and input read
    wr(ra(1, 0), 8'h0F);
    wr(ra(1, 1), 8'hF0);
    check("R4 pin_out", 32'(pin_out), 32'hF00F);
    check("R3 oe kept", 32'(pin_oe), 32'h3CA5);
    rd(ra(1, 0), 8'h00, "R4 level is input");
    @(negedge clk) pin_in = 16'h8001;
    settle(4);
    rd(ra(1, 0), 8'h01, "R4 level bank0");
    rd(ra(1, 1), 8'h80, "R4 level bank1");
    check("R7 irq disabled", 32'(irq), 32'h0);

    // R5 status set on rising change and cleared by read
    rd(ra(3, 0), 8'h01, "R5 stat bank0");
    rd(ra(3, 1), 8'h80, "R5 stat bank1");
    rd(ra(3, 1), 8'h00, "R5 stat cleared");

    // R6 falling change on enabled pin raises irq
    wr(ra(2, 1), 8'h80);
    rd(ra(2, 1), 8'h80, "R7 ien readback");
    @(negedge clk) pin_in = 16'h0001;
    settle(5);
    check("R6 irq high", 32'(irq), 32'h1);
    rd(ra(3, 1), 8'h80, "R6 stat fall");
    settle(2);
    check("R6 irq low", 32'(irq), 32'h0);

    // R7 change on disabled bank: visible, no irq
    @(negedge clk) pin_in = 16'h0000;
    settle(5);
    check("R7 no irq", 32'(irq), 32'h0);
    rd(ra(3, 0), 8'h01, "R7 stat visible");

    // R8 spare storage
    wr(ra(4, 0), 8'h5A);
    wr(ra(4, 1), 8'hC3);
    rd(ra(4, 0), 8'h5A, "R8 spare bank0");
    rd(ra(4, 1), 8'hC3, "R8 spare bank1");

    // R9 unused addresses
    for (int a = 5 * BANKS; a < NADDR; a++) wr(ADDR_W'(a), 8'hFF);
    for (int a = 5 * BANKS; a < NADDR; a++) rd(ADDR_W'(a), 8'h00, "R9 unused read");
    rd(ra(0, 0), 8'hA5, "R9 dir kept");
    rd(ra(2, 0), 8'h00, "R9 ien kept");
    rd(ra(4, 1), 8'hC3, "R9 spare kept");
    check("R9 out kept", 32'(pin_out), 32'hF00F);
    check("R9 oe kept", 32'(pin_oe), 32'h3CA5);

    // R10 status writes ignored
    @(negedge clk) pin_in = 16'h0002;
    settle(5);
    wr(ra(3, 0), 8'h00);
    rd(ra(3, 0), 8'h02, "R10 stat write ignored");
    wr(ra(3, 1), 8'hFF);
    rd(ra(3, 1), 8'h00, "R10 stat not set");
    check("R10 irq", 32'(irq), 32'h0);

    // R5 event in the clearing-read cycle survives
    @(negedge clk) pin_in = 16'h0006;
    @(negedge clk);
    rd(ra(3, 0), 8'h00, "R5 race old value");
    rd(ra(3, 0), 8'h04, "R5 race set wins");

    settle(3);
    check("R11 queue drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule